// File: doc/BRIEF.md
# PIO Register-Cycle Host Sequencer

This block sits on the host side of a parallel ATA style bus and runs one register read or register write at a time. A requester offers a chip-select pair, a 3-bit register number, a direction bit and a write byte through a valid/ready handshake. The sequencer latches them and drives the address lines through a setup phase. It then pulses the matching strobe, moves one byte over the low half of the 16-bit data bus, and keeps the address through a hold phase. A recovery gap follows, and the cycle ends with a one-cycle completion pulse.

Every phase length is a clock count taken from a configuration input. The device's ready line passes through a two-flop synchronizer. It is examined once, at a configured offset into the strobe. If it is low at that point, the strobe stays asserted until ready returns, and on a read the byte is captured when ready is seen again. A configured wait limit ends a cycle that has stalled, and flags an error.

Top module: `pio_reg_seq`

## Requirements
- R1: Out of reset the bus is idle: both chip selects high, both strobes high, the data driver off, `reqReady` high and `doneValid` low.
- R2: A request is latched on the edge where `reqValid` and `reqReady` are both high. Chip selects and register address show the latched values for max(`cfgSetup`,1) cycles before the strobe falls, and stay unchanged through the hold phase even if the request inputs change.
- R3: A read (`reqWrite`=0) pulses only `ideRdN`, a write (`reqWrite`=1) pulses only `ideWrN`; the two are never low together.
- R4: Without a wait, the strobe stays low for max(`cfgActive`, `cfgSample`+3) cycles.
- R5: The ready decision uses only the pin level at the end of strobe cycle number `cfgSample` (counting from 0 at the first low cycle). A low pulse on ready that ends before that point adds no wait.
- R6: If ready is low at the decision point, the strobe stays low until ready is seen high again. With ready first high at the end of strobe cycle k, the strobe is low for k+3 cycles.
- R7: A read returns `ideDataIn[7:0]` from the last strobe cycle on `doneRdata`. On a waited read, that cycle is the one where the returning ready is seen. A write returns 0.
- R8: On a write, `ideDataOe` is high and `ideDataOut` equals {8'h00, write byte} from the first strobe cycle through the last hold cycle. On a read, `ideDataOe` stays low.
- R9: After the strobe rises, the address is held for max(`cfgHold`,1) cycles. Both chip selects then stay high for max(`cfgRecover`,1) cycles. `doneValid` pulses in the next cycle.
- R10: If ready stays low, the wait ends after max(`cfgTimeout`,1) wait cycles, so the strobe is low for `cfgSample`+3+max(`cfgTimeout`,1) cycles. `doneErr` is 1 and `doneRdata` is 0. Otherwise `doneErr` is 0.
- R11: `reqReady` is high only when no cycle is in progress. `doneValid` lasts exactly one cycle and coincides with `reqReady` returning high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request will be taken |
| reqWrite | input | 1 | 1 = register write, 0 = register read |
| reqCsN | input | 2 | Active-low chip-select pattern for the cycle |
| reqAddr | input | 3 | Register number |
| reqWdata | input | 8 | Write byte |
| cfgSetup | input | CNT_W | Address setup cycles |
| cfgActive | input | CNT_W | Minimum strobe low cycles |
| cfgSample | input | CNT_W | Strobe cycle whose ready level decides the wait |
| cfgHold | input | CNT_W | Address hold cycles after strobe rises |
| cfgRecover | input | CNT_W | Idle-bus cycles before completion |
| cfgTimeout | input | TO_W | Wait-state limit in cycles |
| ideCsN | output | 2 | Chip selects to the device |
| ideAddr | output | 3 | Register address to the device |
| ideRdN | output | 1 | Read strobe, active low |
| ideWrN | output | 1 | Write strobe, active low |
| ideDataOut | output | 16 | Data bus value driven by the host |
| ideDataOe | output | 1 | Host data driver enable |
| ideDataIn | input | 16 | Data bus value seen by the host |
| ideRdy | input | 1 | Device ready line (low = extend) |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 8 | Captured read byte |
| doneErr | output | 1 | Cycle ended by wait timeout |

## Verification
The bench places a low pulse on ready around the decision point: one pulse ends a cycle before it and one covers it. A design that sampled at the wrong offset would add a wait where none belongs, or skip one. A long wait is paired with read data that becomes valid only just before ready returns. A design that captured on the normal strobe end, rather than on ready, would return garbage. A ready line held low must end in the timeout width with the error set, and the following cycle must run cleanly. The request inputs are scrambled right after acceptance to catch address lines that are not latched.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_HOLD,
    ST_RECOVER
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch the request
    logic capture;  // latch read data
    logic abort;    // wait limit hit
    logic addrOn;   // address lines valid
    logic strobe;   // strobe asserted
    logic drive;    // write data window
    logic done;     // completion pulse
  } ctrl_s;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             rdySync,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgActive,
  input  logic [CNT_W-1:0] cfgSample,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgRecover,
  input  logic [TO_W-1:0]  cfgTimeout,
  output logic             reqReady,
  output ctrl_s            ctrl
);

  localparam int PW = (TO_W > CNT_W + 2) ? TO_W : CNT_W + 2;
  localparam int SYNC_LAT = 2;

  phase_e          state, nextState;
  logic [PW-1:0]   phaseCnt, cntNext, sampleAt;
  logic            doneQ, captureNow, abortNow;

  always_comb begin
    cntNext    = phaseCnt + 1'b1;
    sampleAt   = PW'(cfgSample) + PW'(SYNC_LAT);
    nextState  = state;
    captureNow = 1'b0;
    abortNow   = 1'b0;
    unique case (state)
      ST_IDLE:    if (reqValid) nextState = ST_SETUP;
      ST_SETUP:   if (cntNext >= PW'(cfgSetup)) nextState = ST_STROBE;
      ST_STROBE: begin
        if (phaseCnt == sampleAt && !rdySync) begin
          nextState = ST_WAIT;
        end else if (phaseCnt >= sampleAt && cntNext >= PW'(cfgActive)) begin
          nextState  = ST_HOLD;
          captureNow = 1'b1;
        end
      end
      ST_WAIT: begin
        if (rdySync) begin
          nextState  = ST_HOLD;
          captureNow = 1'b1;
        end else if (cntNext >= PW'(cfgTimeout)) begin
          nextState = ST_HOLD;
          abortNow  = 1'b1;
        end
      end
      ST_HOLD:    if (cntNext >= PW'(cfgHold)) nextState = ST_RECOVER;
      ST_RECOVER: if (cntNext >= PW'(cfgRecover)) nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      doneQ    <= 1'b0;
    end else begin
      state    <= nextState;
      phaseCnt <= (nextState != state || state == ST_IDLE) ? '0 : cntNext;
      doneQ    <= (state == ST_RECOVER) && (nextState == ST_IDLE);
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign ctrl.load    = (state == ST_IDLE) && reqValid;
  assign ctrl.capture = captureNow;
  assign ctrl.abort   = abortNow;
  assign ctrl.addrOn  = (state == ST_SETUP) || (state == ST_STROBE) ||
                        (state == ST_WAIT)  || (state == ST_HOLD);
  assign ctrl.strobe  = (state == ST_STROBE) || (state == ST_WAIT);
  assign ctrl.drive   = ctrl.strobe || (state == ST_HOLD);
  assign ctrl.done    = doneQ;

  // R5: strobe cannot end before the ready decision point
  p_no_early_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && phaseCnt < sampleAt) |=> ctrl.strobe);

  // R6: a wait with ready low and no timeout keeps the strobe
  p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !rdySync && !abortNow) |=> ctrl.strobe);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.done |=> !ctrl.done);

  // R11: ready to accept only with the bus released
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !ctrl.addrOn);

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrl_s       ctrl,
  input  logic        reqWrite,
  input  logic [1:0]  reqCsN,
  input  logic [2:0]  reqAddr,
  input  logic [7:0]  reqWdata,
  input  logic [15:0] ideDataIn,
  input  logic        ideRdy,
  output logic        rdySync,
  output logic [1:0]  ideCsN,
  output logic [2:0]  ideAddr,
  output logic        ideRdN,
  output logic        ideWrN,
  output logic [15:0] ideDataOut,
  output logic        ideDataOe,
  output logic        doneValid,
  output logic [7:0]  doneRdata,
  output logic        doneErr
);

  logic [1:0] syncQ;
  logic       isWrite, errReg;
  logic [1:0] csReg;
  logic [2:0] addrReg;
  logic [7:0] wdReg, rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], ideRdy};
  end
  assign rdySync = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite <= 1'b0;
      csReg   <= 2'b11;
      addrReg <= '0;
      wdReg   <= '0;
      rdReg   <= '0;
      errReg  <= 1'b0;
    end else if (ctrl.load) begin
      isWrite <= reqWrite;
      csReg   <= reqCsN;
      addrReg <= reqAddr;
      wdReg   <= reqWdata;
      rdReg   <= '0;
      errReg  <= 1'b0;
    end else if (ctrl.abort) begin
      rdReg  <= '0;
      errReg <= 1'b1;
    end else if (ctrl.capture && !isWrite) begin
      rdReg <= ideDataIn[7:0];
    end
  end

  assign ideCsN     = ctrl.addrOn ? csReg : 2'b11;
  assign ideAddr    = ctrl.addrOn ? addrReg : 3'd0;
  assign ideRdN     = !(ctrl.strobe && !isWrite);
  assign ideWrN     = !(ctrl.strobe && isWrite);
  assign ideDataOe  = ctrl.drive && isWrite;
  assign ideDataOut = ideDataOe ? {8'h00, wdReg} : 16'h0000;
  assign doneValid  = ctrl.done;
  assign doneRdata  = rdReg;
  assign doneErr    = errReg;

  // R3: never both strobes
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!ideRdN && !ideWrN));

  // R8: write strobe always has the driver on, read strobe never
  p_write_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ideWrN |-> ideDataOe);
  p_read_no_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ideRdN |-> !ideDataOe);

  // R2: address lines do not move under an asserted strobe
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(ideRdN && ideWrN) && $past(!(ideRdN && ideWrN))) |->
      ($stable(ideAddr) && $stable(ideCsN)));

endmodule

// File: rtl/pio_reg_seq.sv
module pio_reg_seq
  import pio_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [1:0]       reqCsN,
  input  logic [2:0]       reqAddr,
  input  logic [7:0]       reqWdata,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgActive,
  input  logic [CNT_W-1:0] cfgSample,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgRecover,
  input  logic [TO_W-1:0]  cfgTimeout,
  output logic [1:0]       ideCsN,
  output logic [2:0]       ideAddr,
  output logic             ideRdN,
  output logic             ideWrN,
  output logic [15:0]      ideDataOut,
  output logic             ideDataOe,
  input  logic [15:0]      ideDataIn,
  input  logic             ideRdy,
  output logic             doneValid,
  output logic [7:0]       doneRdata,
  output logic             doneErr
);

  ctrl_s ctrl;
  logic  rdySync;

  pio_ctrl #(.CNT_W(CNT_W), .TO_W(TO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rdySync(rdySync),
    .cfgSetup(cfgSetup), .cfgActive(cfgActive), .cfgSample(cfgSample),
    .cfgHold(cfgHold), .cfgRecover(cfgRecover), .cfgTimeout(cfgTimeout),
    .reqReady(reqReady), .ctrl(ctrl)
  );

  pio_datapath uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqWrite(reqWrite), .reqCsN(reqCsN), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ideDataIn(ideDataIn), .ideRdy(ideRdy), .rdySync(rdySync),
    .ideCsN(ideCsN), .ideAddr(ideAddr), .ideRdN(ideRdN), .ideWrN(ideWrN),
    .ideDataOut(ideDataOut), .ideDataOe(ideDataOe),
    .doneValid(doneValid), .doneRdata(doneRdata), .doneErr(doneErr)
  );

endmodule

// File: tb/sim_pio_reg_seq.sv
module sim_pio_reg_seq;

  localparam int CNT_W = 8;
  localparam int TO_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic             reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [1:0]       reqCsN = 2'b11;
  logic [2:0]       reqAddr = '0;
  logic [7:0]       reqWdata = '0;
  logic [CNT_W-1:0] cfgSetup = 8'd3, cfgActive = 8'd6, cfgSample = 8'd2;
  logic [CNT_W-1:0] cfgHold = 8'd1, cfgRecover = 8'd2;
  logic [TO_W-1:0]  cfgTimeout = 16'd20;
  logic [1:0]       ideCsN;
  logic [2:0]       ideAddr;
  logic             ideRdN, ideWrN, ideDataOe, doneValid, doneErr;
  logic [15:0]      ideDataOut;
  logic [15:0]      ideDataIn = 16'hEEEE;
  logic             ideRdy = 1'b1;
  logic [7:0]       doneRdata;

  pio_reg_seq #(.CNT_W(CNT_W), .TO_W(TO_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqCsN(reqCsN), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgSetup(cfgSetup), .cfgActive(cfgActive), .cfgSample(cfgSample),
    .cfgHold(cfgHold), .cfgRecover(cfgRecover), .cfgTimeout(cfgTimeout),
    .ideCsN(ideCsN), .ideAddr(ideAddr), .ideRdN(ideRdN), .ideWrN(ideWrN),
    .ideDataOut(ideDataOut), .ideDataOe(ideDataOe), .ideDataIn(ideDataIn),
    .ideRdy(ideRdy), .doneValid(doneValid), .doneRdata(doneRdata), .doneErr(doneErr)
  );

  typedef struct {
    logic       wr;
    logic [1:0] cs;
    logic [2:0] addr;
    logic [7:0] wd;
    logic [7:0] rd;
    logic       err;
    int         width;
    int         setup;
    int         hold;
    int         rec;
  } item_t;

  item_t expQ[$];
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishSim();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Device model
  int devLowFrom = 0, devLowTo = 0, devValidFrom = 0;
  logic [7:0] devByte = 8'h00;
  int age = -1;
  always @(negedge clk) begin
    if (!ideRdN || !ideWrN) age = age + 1;
    else age = -1;
    ideRdy    <= !(age >= 0 && age >= devLowFrom && age < devLowTo);
    ideDataIn <= (age >= 0 && age >= devValidFrom) ? {8'h11, devByte} : 16'hEEEE;
  end

  // Monitor / scoreboard
  int setupCnt = 0, widthCnt = 0, holdCnt = 0, recCnt = 0;
  bit seenStrobe = 0, addrBad = 0, oeBad = 0, strobeBad = 0, readyBad = 0;
  bit prevDone = 0;
  always @(negedge clk) begin
    if (rstN) begin
      automatic bit strobeOn = !ideRdN || !ideWrN;
      automatic bit csOn = (ideCsN != 2'b11);
      if (prevDone && doneValid) check(0, "R11", "done width", 2, 1);
      prevDone = doneValid;
      if (reqReady && csOn) readyBad = 1;
      if (expQ.size() > 0) begin
        automatic item_t f = expQ[0];
        if (csOn && (ideCsN != f.cs || ideAddr != f.addr)) addrBad = 1;
        if (strobeOn && (f.wr ? ideWrN : ideRdN)) strobeBad = 1;
        if (strobeOn || (seenStrobe && csOn)) begin
          if (f.wr && (!ideDataOe || ideDataOut != {8'h00, f.wd})) oeBad = 1;
        end
        if (!f.wr && ideDataOe) oeBad = 1;
      end
      if (strobeOn) begin
        seenStrobe = 1;
        widthCnt++;
      end else if (csOn && !seenStrobe) setupCnt++;
      else if (csOn && seenStrobe) holdCnt++;
      else if (seenStrobe && !doneValid) recCnt++;
      if (doneValid) begin
        if (expQ.size() == 0) check(0, "R11", "unexpected done", 1, 0);
        else begin
          automatic item_t e = expQ.pop_front();
          check(doneRdata == e.rd, "R7", "rdata", doneRdata, e.rd);
          check(doneErr == e.err, "R10", "err", doneErr, e.err);
          check(widthCnt == e.width, "R4/R6", "strobe width", widthCnt, e.width);
          check(setupCnt == e.setup, "R2", "setup cycles", setupCnt, e.setup);
          check(holdCnt == e.hold, "R9", "hold cycles", holdCnt, e.hold);
          check(recCnt == e.rec, "R9", "recover cycles", recCnt, e.rec);
          check(!addrBad, "R2", "address latched", addrBad, 0);
          check(!strobeBad, "R3", "strobe select", strobeBad, 0);
          check(!oeBad, "R8", "data drive", oeBad, 0);
          check(!readyBad && reqReady, "R11", "reqReady", readyBad, 0);
        end
        setupCnt = 0; widthCnt = 0; holdCnt = 0; recCnt = 0;
        seenStrobe = 0; addrBad = 0; oeBad = 0; strobeBad = 0; readyBad = 0;
      end
    end
  end

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Driver: lowFrom/lowTo give the strobe-cycle window where ready is low
  task automatic runTxn(input bit wr, input logic [1:0] cs, input logic [2:0] addr,
                        input logic [7:0] wd, input logic [7:0] dev,
                        input int lowFrom, input int lowTo);
    item_t it;
    bit waits;
    int smp, tmo;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    smp   = int'(cfgSample);
    tmo   = maxi(int'(cfgTimeout), 1);
    waits = (smp >= lowFrom) && (smp < lowTo);
    it.wr = wr; it.cs = cs; it.addr = addr; it.wd = wd;
    it.setup = maxi(int'(cfgSetup), 1);
    it.hold  = maxi(int'(cfgHold), 1);
    it.rec   = maxi(int'(cfgRecover), 1);
    it.err   = 1'b0;
    it.rd    = wr ? 8'h00 : dev;
    if (!waits) it.width = maxi(int'(cfgActive), smp + 3);
    else if (lowTo > smp + tmo) begin
      it.width = smp + 3 + tmo;
      it.err   = 1'b1;
      it.rd    = 8'h00;
    end else it.width = lowTo + 3;
    devLowFrom = lowFrom; devLowTo = lowTo;
    devValidFrom = waits ? lowTo - 1 : 0;
    devByte = dev;
    expQ.push_back(it);
    reqValid = 1'b1; reqWrite = wr; reqCsN = cs; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    // scramble request after acceptance (R2)
    reqValid = 1'b0; reqWrite = ~wr; reqCsN = ~cs; reqAddr = ~addr; reqWdata = ~wd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R11", "watchdog", 1, 0);
    finishSim();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ideCsN == 2'b11 && ideRdN && ideWrN, "R1", "bus idle", {ideCsN, ideRdN, ideWrN}, 15);
    check(!ideDataOe && reqReady && !doneValid, "R1", "oe/ready/done",
          {ideDataOe, reqReady, doneValid}, 2);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runTxn(1, 2'b10, 3'd5, 8'h3C, 8'h00, 0, 0);     // R3 R4 R8 write
    runTxn(0, 2'b01, 3'd2, 8'h00, 8'h5A, 0, 0);     // R7 read
    runTxn(0, 2'b10, 3'd7, 8'h00, 8'hC3, 0, 2);     // R5 early pulse, no wait
    runTxn(0, 2'b10, 3'd1, 8'h00, 8'h96, 0, 3);     // R5 R6 boundary wait
    runTxn(0, 2'b01, 3'd4, 8'h00, 8'h77, 1, 12);    // R6 R7 long wait, late data
    runTxn(0, 2'b01, 3'd6, 8'h00, 8'h12, 0, 1000);  // R10 timeout
    runTxn(1, 2'b10, 3'd3, 8'hA1, 8'h00, 0, 8);     // R6 R8 write with wait
    while (!reqReady || expQ.size() != 0) @(negedge clk);
    cfgSetup = 8'd0; cfgActive = 8'd10; cfgSample = 8'd4;
    cfgHold = 8'd0; cfgRecover = 8'd4; cfgTimeout = 16'd0;
    runTxn(0, 2'b10, 3'd0, 8'h00, 8'h4E, 0, 0);     // R2 R4 R9 zero counts
    runTxn(0, 2'b01, 3'd2, 8'h00, 8'h2B, 4, 1000);  // R10 timeout of 1
    while (!reqReady || expQ.size() != 0) @(negedge clk);
    cfgSetup = 8'd5; cfgActive = 8'd3; cfgSample = 8'd1;
    cfgHold = 8'd3; cfgRecover = 8'd0; cfgTimeout = 16'd30;
    runTxn(1, 2'b10, 3'd6, 8'hF0, 8'h00, 0, 0);     // R4 sample bound dominates
    runTxn(0, 2'b10, 3'd5, 8'h00, 8'h81, 1, 9);     // R6 with new sample point
    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, "R11", "all done", expQ.size(), 0);
    finishSim();
  end

endmodule